// File: doc/BRIEF.md
# Multicycle Accumulator Processor Controller

This block is a small multicycle processor built around a program counter, a memory address register, a memory buffer register, an instruction register and a single accumulator. It owns one word-wide external memory port. That port has a registered address bus, a registered write-data bus, an input read-data bus, and separate read and write strobes. Every instruction starts with an explicit fetch phase. In that phase the program counter is copied into the address register, the instruction word is read, and the word is moved through the buffer register into the instruction register. An execute phase follows, and it moves each operand one bus transaction at a time.

The instruction word is 40 bits. A 4-bit opcode sits at the top, and three 12-bit address fields sit below it. The machine supports load, store, add, halt and a memory-to-memory three-address multiply. The multiply reads both sources through the buffer register into the accumulator, forms the product, and writes the low 40 bits to the destination. Arithmetic overflow and illegal opcodes raise a sticky program-interrupt condition. An illegal opcode also stops the machine until reset. Memory is assumed synchronous: read data appears on the bus one clock after the strobed cycle.

Top module: `mc_acc_cpu`

## Requirements
- R1: After synchronous reset the program counter, instruction register, accumulator and both cause bits are zero, both strobes are low and `halted` is low. A STORE executed first therefore writes 0.
- R2: Each fetch reads the address held in the program counter, starting at 0. The program counter advances by one at the end of every fetch, so instruction fetches go to consecutive addresses.
- R3: `mem_rd` and `mem_wr` are never high in the same cycle. Each strobe is high for exactly one cycle per access.
- R4: Instruction encoding uses fixed field positions:
  - bits 39:36 hold the opcode;
  - bits 35:24 hold source 1;
  - bits 23:12 hold source 2;
  - bits 11:0 hold the destination, which is also the single address used by LOAD, STORE and ADD.
- R5: The opcodes are HALT=0, LOAD=1, STORE=2, ADD=3 and MUL=4. LOAD copies memory into the accumulator. STORE writes the accumulator to memory, and the write data always equals the accumulator.
- R6: ADD forms the accumulator plus memory modulo 2^40. A carry out of bit 39 sets `irq_cause[1]` and `prog_irq`, and execution continues.
- R7: MUL writes the low 40 bits of mem[src1]*mem[src2] (unsigned) to mem[dst] and leaves that value in the accumulator.
- R8: A MUL whose product has any bit above bit 39 set raises `irq_cause[1]` and `prog_irq`. The truncated result is still written, and the cause bit stays set until reset.
- R9: Opcodes 5 to 15 are illegal. An illegal opcode sets `irq_cause[0]`, `prog_irq` and `halted`, and it performs no memory access. The block then stays halted with no bus activity until reset.
- R10: HALT sets `halted` without raising `prog_irq`. After it the bus stays idle.
- R11: A MUL performs, in order: a read of source 1, a read of source 2, then a write of the destination. Each is a separate bus transaction.
- R12: A reset applied at any time clears `halted`, `prog_irq` and `irq_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address (registered address register) |
| mem_rd | output | 1 | Read strobe, one cycle per access |
| mem_wr | output | 1 | Write strobe, one cycle per access |
| mem_wdata | output | 40 | Write data (registered buffer register) |
| mem_rdata | input | 40 | Read data, valid the cycle after a read strobe |
| halted | output | 1 | Machine stopped by HALT or illegal opcode |
| prog_irq | output | 1 | Program interrupt pending |
| irq_cause | output | 2 | Bit 0 illegal opcode, bit 1 arithmetic overflow |

## Verification
The embedded properties watch, every cycle, the rules that hold whatever the program is:
- the strobes stay exclusive and last one cycle;
- the program counter steps by one after each fetch;
- write data equals the accumulator;
- an illegal decode lands in the halted state;
- halted and overflow state are sticky.

The arithmetic results, the modular wrap and the product truncation can only be shown by the bench's programs, which compare memory contents against expected values. The same holds for the exact order of bus transactions during a multiply, for the silence of the bus after a stop, and for clearing by a mid-run reset.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'd0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_MUL   = 4'd4;

  typedef enum logic [3:0] {
    ST_F_ADDR,
    ST_F_BUS,
    ST_F_CAPT,
    ST_F_IR,
    ST_DECODE,
    ST_O_BUS,
    ST_O_CAPT,
    ST_EXEC,
    ST_W_PREP,
    ST_W_BUS,
    ST_HALT
  } seq_state_e;

  localparam int CAUSE_ILLEGAL = 0;
  localparam int CAUSE_OVF     = 1;

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int DATA_W = 40
) (
  input  logic              op_mul,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res,
  output logic              ovf
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = DATA_W + 1;

  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    prod = {{DATA_W{1'b0}}, opa} * {{DATA_W{1'b0}}, opb};
    sum  = {1'b0, opa} + {1'b0, opb};
    if (op_mul) begin
      res = prod[DATA_W-1:0];
      ovf = |prod[PROD_W-1:DATA_W];
    end else begin
      res = sum[DATA_W-1:0];
      ovf = sum[DATA_W];
    end
  end

endmodule

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int ADDR_W = 12
) (
  input  logic [DATA_W-1:0] ir,
  output logic              is_halt,
  output logic              is_load,
  output logic              is_store,
  output logic              is_add,
  output logic              is_mul,
  output logic              illegal,
  output logic [ADDR_W-1:0] src1,
  output logic [ADDR_W-1:0] src2,
  output logic [ADDR_W-1:0] dst
);

  localparam int OPND_W = DATA_W - OPC_W;
  localparam int S1_HI  = 3 * ADDR_W - 1;
  localparam int S2_HI  = 2 * ADDR_W - 1;

  logic [OPC_W-1:0]  opc;
  logic [OPND_W-1:0] opnd;

  assign opc  = ir[DATA_W-1 -: OPC_W];
  assign opnd = ir[OPND_W-1:0];
  assign src1 = opnd[S1_HI -: ADDR_W];
  assign src2 = opnd[S2_HI -: ADDR_W];
  assign dst  = opnd[ADDR_W-1:0];

  always_comb begin
    is_halt  = 1'b0;
    is_load  = 1'b0;
    is_store = 1'b0;
    is_add   = 1'b0;
    is_mul   = 1'b0;
    illegal  = 1'b0;
    case (opc)
      OP_HALT:  is_halt  = 1'b1;
      OP_LOAD:  is_load  = 1'b1;
      OP_STORE: is_store = 1'b1;
      OP_ADD:   is_add   = 1'b1;
      OP_MUL:   is_mul   = 1'b1;
      default:  illegal  = 1'b1;
    endcase
  end

endmodule

// File: rtl/cpu_seq.sv
module cpu_seq
  import cpu_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_halt,
  input  logic              is_load,
  input  logic              is_store,
  input  logic              is_add,
  input  logic              is_mul,
  input  logic              illegal,
  input  logic [ADDR_W-1:0] src1,
  input  logic [ADDR_W-1:0] src2,
  input  logic [ADDR_W-1:0] dst,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_ovf,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic              rd_q,
  output logic              wr_q,
  output logic              halted_q,
  output logic [1:0]        cause_q
);

  seq_state_e        state;
  logic [ADDR_W-1:0] pc_q;
  logic              mul_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_F_ADDR;
      pc_q     <= '0;
      mar_q    <= '0;
      mbr_q    <= '0;
      ir_q     <= '0;
      acc_q    <= '0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      halted_q <= 1'b0;
      cause_q  <= '0;
      mul_step <= 1'b0;
    end else begin
      case (state)
        // fetch: PC -> MAR, bus read, MBR capture, MBR -> IR
        ST_F_ADDR: begin
          mar_q <= pc_q;
          rd_q  <= 1'b1;
          state <= ST_F_BUS;
        end
        ST_F_BUS: begin
          rd_q  <= 1'b0;
          state <= ST_F_CAPT;
        end
        ST_F_CAPT: begin
          mbr_q <= mem_rdata;
          state <= ST_F_IR;
        end
        ST_F_IR: begin
          ir_q  <= mbr_q;
          pc_q  <= pc_q + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          mul_step <= 1'b0;
          if (illegal) begin
            cause_q[CAUSE_ILLEGAL] <= 1'b1;
            halted_q <= 1'b1;
            state    <= ST_HALT;
          end else if (is_halt) begin
            halted_q <= 1'b1;
            state    <= ST_HALT;
          end else if (is_store) begin
            mar_q <= dst;
            state <= ST_W_PREP;
          end else if (is_mul) begin
            mar_q <= src1;
            rd_q  <= 1'b1;
            state <= ST_O_BUS;
          end else begin
            mar_q <= dst;
            rd_q  <= 1'b1;
            state <= ST_O_BUS;
          end
        end
        // operand read
        ST_O_BUS: begin
          rd_q  <= 1'b0;
          state <= ST_O_CAPT;
        end
        ST_O_CAPT: begin
          mbr_q <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (is_load) begin
            acc_q <= mbr_q;
            state <= ST_F_ADDR;
          end else if (is_add) begin
            acc_q <= alu_res;
            if (alu_ovf) cause_q[CAUSE_OVF] <= 1'b1;
            state <= ST_F_ADDR;
          end else if (!mul_step) begin
            acc_q    <= mbr_q;
            mar_q    <= src2;
            rd_q     <= 1'b1;
            mul_step <= 1'b1;
            state    <= ST_O_BUS;
          end else begin
            acc_q <= alu_res;
            if (alu_ovf) cause_q[CAUSE_OVF] <= 1'b1;
            mar_q <= dst;
            state <= ST_W_PREP;
          end
        end
        // store: ACC -> MBR, bus write
        ST_W_PREP: begin
          mbr_q <= acc_q;
          wr_q  <= 1'b1;
          state <= ST_W_BUS;
        end
        ST_W_BUS: begin
          wr_q  <= 1'b0;
          state <= ST_F_ADDR;
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_HALT;
      endcase
    end
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));
  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> !rd_q);
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    wr_q |=> !wr_q);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_F_IR) |=> (pc_q == $past(pc_q) + 1'b1));
  assert_store_src_R5: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> (mbr_q == acc_q));
  assert_illegal_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && illegal) |=> (halted_q && cause_q[CAUSE_ILLEGAL]));
  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (halted_q && !rd_q && !wr_q));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cause_q[CAUSE_OVF] |=> cause_q[CAUSE_OVF]);
  assert_class_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot({is_halt, is_load, is_store, is_add, is_mul, illegal}));

endmodule

// File: rtl/mc_acc_cpu.sv
module mc_acc_cpu #(
  parameter int DATA_W = 40,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic              prog_irq,
  output logic [1:0]        irq_cause
);

  logic [DATA_W-1:0] ir_q, acc_q, mbr_q, alu_res;
  logic [ADDR_W-1:0] src1, src2, dst;
  logic is_halt, is_load, is_store, is_add, is_mul, illegal, alu_ovf;

  cpu_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .ir(ir_q), .is_halt(is_halt), .is_load(is_load), .is_store(is_store),
    .is_add(is_add), .is_mul(is_mul), .illegal(illegal),
    .src1(src1), .src2(src2), .dst(dst)
  );

  cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_mul(is_mul), .opa(acc_q), .opb(mbr_q), .res(alu_res), .ovf(alu_ovf)
  );

  cpu_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst),
    .is_halt(is_halt), .is_load(is_load), .is_store(is_store),
    .is_add(is_add), .is_mul(is_mul), .illegal(illegal),
    .src1(src1), .src2(src2), .dst(dst),
    .alu_res(alu_res), .alu_ovf(alu_ovf), .mem_rdata(mem_rdata),
    .ir_q(ir_q), .acc_q(acc_q), .mbr_q(mbr_q), .mar_q(mem_addr),
    .rd_q(mem_rd), .wr_q(mem_wr), .halted_q(halted), .cause_q(irq_cause)
  );

  assign mem_wdata = mbr_q;
  assign prog_irq  = |irq_cause;

endmodule

// File: tb/mc_acc_cpu_test.sv
`timescale 1ns/1ps
module mc_acc_cpu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted, prog_irq;
  logic [39:0] mem_wdata;
  logic [39:0] mem_rdata = '0;
  logic [1:0]  irq_cause;

  always #2 clk = ~clk;

  mc_acc_cpu uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
    .prog_irq(prog_irq), .irq_cause(irq_cause)
  );

  logic [39:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  // bus monitor: {is_write, addr}
  logic [12:0] log_q [0:63];
  int log_n = 0;
  int strobe_bad = 0;
  logic prev_rd = 1'b0, prev_wr = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd && mem_wr) strobe_bad++;
      if ((mem_rd && prev_rd) || (mem_wr && prev_wr)) strobe_bad++;
      if ((mem_rd || mem_wr) && log_n < 64) begin
        log_q[log_n] = {mem_wr, mem_addr};
        log_n++;
      end
    end
    prev_rd = mem_rd;
    prev_wr = mem_wr;
  end

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] enc(input logic [3:0] op, input logic [11:0] s1,
                                      input logic [11:0] s2, input logic [11:0] d);
    return {op, s1, s2, d};
  endfunction

  task automatic hold_reset();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    log_n = 0;
  endtask

  task automatic run_to_halt();
    int n;
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // {src1 value, src2 value, expected low product, expected overflow}
  localparam logic [120:0] VEC [0:7] = '{
    {40'd3,            40'd5,      40'd15,           1'b0},
    {40'd0,            40'hFFFFFFFFFF, 40'd0,        1'b0},
    {40'd1048576,      40'd524288, 40'h8000000000,   1'b0},
    {40'd1048576,      40'd1048576, 40'd0,           1'b1},
    {40'hFFFFFFFFFF,   40'd1,      40'hFFFFFFFFFF,   1'b0},
    {40'hFFFFFFFFFF,   40'd2,      40'hFFFFFFFFFE,   1'b1},
    {40'd12345,        40'd6789,   40'd83810205,     1'b0},
    {40'h1000000001,   40'd16,     40'd16,           1'b1}
  };

  localparam logic [12:0] MUL_BUS [0:6] = '{
    {1'b0, 12'd0}, {1'b0, 12'd100}, {1'b0, 12'd101}, {1'b1, 12'd102},
    {1'b0, 12'd1}, {1'b1, 12'd103}, {1'b0, 12'd2}
  };

  localparam logic [12:0] SEQ_BUS [0:8] = '{
    {1'b0, 12'd0}, {1'b1, 12'd200}, {1'b0, 12'd1}, {1'b0, 12'd201},
    {1'b0, 12'd2}, {1'b0, 12'd202}, {1'b0, 12'd3}, {1'b1, 12'd203},
    {1'b0, 12'd4}
  };

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    hold_reset();
    check("R1 halted", {39'd0, halted}, 40'd0);
    check("R1 prog_irq", {39'd0, prog_irq}, 40'd0);
    check("R1 strobes", {38'd0, mem_rd, mem_wr}, 40'd0);
    check("R1 cause", {38'd0, irq_cause}, 40'd0);

    // R7/R8/R4 multiply vectors
    for (int v = 0; v < 8; v++) begin
      hold_reset();
      mem[0]   = enc(4'd4, 12'd100, 12'd101, 12'd102);
      mem[1]   = enc(4'd2, 12'd0, 12'd0, 12'd103);
      mem[2]   = enc(4'd0, 12'd0, 12'd0, 12'd0);
      mem[100] = VEC[v][120:81];
      mem[101] = VEC[v][80:41];
      run_to_halt();
      check("R7 product", mem[102], VEC[v][40:1]);
      check("R7 acc holds product", mem[103], VEC[v][40:1]);
      check("R8 overflow cause", {39'd0, irq_cause[1]}, {39'd0, VEC[v][0]});
      check("R8 prog_irq", {39'd0, prog_irq}, {39'd0, VEC[v][0]});
      if (v == 0) begin
        check("R11 bus count", 40'(log_n), 40'd7);
        for (int k = 0; k < 7; k++)
          check("R11 bus order", {27'd0, log_q[k]}, {27'd0, MUL_BUS[k]});
      end
    end

    // R5/R6/R1/R2 load-add-store sequence
    hold_reset();
    mem[0]   = enc(4'd2, 12'd0, 12'd0, 12'd200);
    mem[1]   = enc(4'd1, 12'd0, 12'd0, 12'd201);
    mem[2]   = enc(4'd3, 12'd0, 12'd0, 12'd202);
    mem[3]   = enc(4'd2, 12'd0, 12'd0, 12'd203);
    mem[4]   = enc(4'd0, 12'd0, 12'd0, 12'd0);
    mem[200] = 40'hABC;
    mem[201] = 40'd1000;
    mem[202] = 40'd234;
    run_to_halt();
    check("R1 accumulator reset", mem[200], 40'd0);
    check("R6 sum", mem[203], 40'd1234);
    check("R6 no overflow", {38'd0, irq_cause}, 40'd0);
    check("R2 bus count", 40'(log_n), 40'd9);
    for (int k = 0; k < 9; k++)
      check("R2 R5 bus sequence", {27'd0, log_q[k]}, {27'd0, SEQ_BUS[k]});

    // R6 add overflow, execution continues
    hold_reset();
    mem[0]   = enc(4'd1, 12'd0, 12'd0, 12'd201);
    mem[1]   = enc(4'd3, 12'd0, 12'd0, 12'd202);
    mem[2]   = enc(4'd2, 12'd0, 12'd0, 12'd203);
    mem[3]   = enc(4'd0, 12'd0, 12'd0, 12'd0);
    mem[201] = 40'hFFFFFFFFFF;
    mem[202] = 40'd2;
    run_to_halt();
    check("R6 wrapped sum", mem[203], 40'd1);
    check("R6 overflow cause", {38'd0, irq_cause}, 40'd2);
    check("R6 prog_irq", {39'd0, prog_irq}, 40'd1);

    // R12 reset clears flags
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 halted cleared", {39'd0, halted}, 40'd0);
    check("R12 prog_irq cleared", {39'd0, prog_irq}, 40'd0);
    check("R12 cause cleared", {38'd0, irq_cause}, 40'd0);

    // R9 illegal opcodes
    for (int op = 5; op < 16; op += 10) begin
      hold_reset();
      mem[0]  = enc(4'(op), 12'd0, 12'd0, 12'd50);
      mem[1]  = enc(4'd2, 12'd0, 12'd0, 12'd50);
      mem[50] = 40'h55;
      run_to_halt();
      repeat (20) @(negedge clk);
      check("R9 halted", {39'd0, halted}, 40'd1);
      check("R9 cause", {38'd0, irq_cause}, 40'd1);
      check("R9 prog_irq", {39'd0, prog_irq}, 40'd1);
      check("R9 memory untouched", mem[50], 40'h55);
      check("R9 only fetch on bus", 40'(log_n), 40'd1);
    end

    // R10 halt
    hold_reset();
    mem[0] = enc(4'd0, 12'd0, 12'd0, 12'd0);
    run_to_halt();
    repeat (20) @(negedge clk);
    check("R10 halted", {39'd0, halted}, 40'd1);
    check("R10 no prog_irq", {39'd0, prog_irq}, 40'd0);
    check("R10 bus idle", 40'(log_n), 40'd1);

    check("R3 strobe violations", 40'(strobe_bad), 40'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule